// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single fetch, read and write requests from a small 8-bit processor core into timed bus cycles on an external memory bus. The low address byte and the data byte share one 8-bit port. The middle address byte goes out on a separate upper port. An address latch enable pulse tells external logic when to capture the low byte. Code fetches use a program-store strobe. Data accesses use separate read and write strobes. During the address phase of data cycles, the upper port briefly carries address bits 23..16, so a second external latch can extend data addressing to 24 bits.

One clock period of the block equals one oscillator period. Every phase of a bus cycle is a whole number of clocks.

A fetch takes 6 clocks:
- phases 0-1: latch enable high
- phase 2: low address held
- phases 3-5: program-store strobe low

A data access takes 12 clocks:
- phases 0-1: latch enable high
- phases 2-4: gap after the latch enable falls
- phases 5-10: read or write strobe low
- phase 11: recovery

The core offers a request while `ready` is high. It receives a one-clock `done` pulse, with `rdata` valid, in the clock after the cycle's last phase. Only one access is in flight at a time.

Top module: `xbus_seq`

## Requirements
- R1: While reset is active, and right after it, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0 (port high impedance), `done` is 0 and `ready` is 1.
- R2: A request with `kind` = 2'b00 (fetch) runs a 6-clock cycle:
  - `ale` is high in phases 0-1.
  - `ad_out` carries `addr[7:0]` with `ad_oe` = 1 in phases 0-2.
  - `hi_port` carries `addr[15:8]` throughout.
  - `psen_n` is low in phases 3-5, with `ad_oe` = 0.
- R3: With fetch requests offered continuously, successive falling edges of `psen_n` are exactly 6 clocks apart.
- R4: `psen_n` stays 1 throughout every data cycle (`kind` 2'b01 read, 2'b10 or 2'b11 write).
- R5: In a data cycle:
  - `ale` is high in phases 0-1, with `addr[7:0]` on `ad_out` and `addr[23:16]` on `hi_port`.
  - `addr[7:0]` stays driven through phase 2.
  - From phase 2 onward, `hi_port` carries `addr[15:8]`.
- R6: The read or write strobe is low for exactly 6 clocks, in phases 5-10, starting 3 clocks after `ale` falls. The two strobes are never low together.
- R7: In a write, `wdata` is driven with `ad_oe` = 1 from phase 3 through phase 11, which covers the whole strobe. In a read, `ad_oe` is 0 from phase 3 to the end.
- R8: Read data is the value on `ad_in` in the last strobe clock: phase 5 for a fetch, phase 10 for a read. It appears on `rdata` together with a one-clock `done` pulse in the clock after the final phase.
- R9: `ready` is 0 from phase 0 to the second-to-last phase and 1 in the last phase. A `req` offered while `ready` is 0 is ignored and leaves the bus cycle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is 1 |
| kind | input | 2 | 00 fetch, 01 read, 1x write |
| addr | input | 24 | Access address (fetch uses bits 15..0) |
| wdata | input | 8 | Write data |
| ready | output | 1 | Block can take a request this clock |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Data captured by the last fetch or read |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed address/data port, driven value |
| ad_oe | output | 1 | Output enable of the multiplexed port |
| ad_in | input | 8 | Multiplexed port, received value |
| hi_port | output | 8 | Upper address port |

## Verification
All bus outputs are decoded directly from registered phase state. They therefore change in the clock after the one in which a request is accepted, and then once per phase. The bench compares every output against a per-phase expectation at the falling edge inside each phase.

The captured byte and the `done` pulse lag the last phase by one register. They are checked at the falling edge of the first clock after the cycle. The bench drives the byte to be captured on `ad_in` only during the one clock that R8 names, and its complement in all other clocks, so capture in any other clock shows up as a wrong `rdata`. The spacing of program-store strobes in back-to-back fetches is measured edge to edge.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int ALE_W     = 2,
  parameter int HOLD_W    = 1,
  parameter int FETCH_LEN = 6,
  parameter int GAP_W     = 3,
  parameter int STB_W     = 6,
  parameter int REC_W     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  kind,
  input  logic [23:0] addr,
  input  logic [7:0]  wdata,
  output logic        ready,
  output logic        done,
  output logic [7:0]  rdata,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  hi_port
);

  localparam int ADR_END  = ALE_W + HOLD_W;
  localparam int STB_BEG  = ALE_W + GAP_W;
  localparam int STB_END  = STB_BEG + STB_W;
  localparam int DATA_LEN = STB_END + REC_W;
  localparam int CW       = $clog2(DATA_LEN + 1);

  localparam logic [CW-1:0] P_ALE   = CW'(ALE_W);
  localparam logic [CW-1:0] P_ADR   = CW'(ADR_END);
  localparam logic [CW-1:0] P_FLAST = CW'(FETCH_LEN - 1);
  localparam logic [CW-1:0] P_SB    = CW'(STB_BEG);
  localparam logic [CW-1:0] P_SE    = CW'(STB_END);
  localparam logic [CW-1:0] P_SCAP  = CW'(STB_END - 1);
  localparam logic [CW-1:0] P_DLAST = CW'(DATA_LEN - 1);

  logic          busy;
  logic [1:0]    kind_q;
  logic [23:0]   addr_q;
  logic [7:0]    wd_q;
  logic [CW-1:0] ph;

  wire is_fetch = (kind_q == 2'b00);
  wire is_rd    = (kind_q == 2'b01);
  wire is_wr    = kind_q[1];
  wire last     = busy && (ph == (is_fetch ? P_FLAST : P_DLAST));
  wire start    = req && ready;
  wire capture  = busy && ((is_fetch && ph == P_FLAST) || (is_rd && ph == P_SCAP));
  wire in_ale   = busy && (ph < P_ALE);
  wire in_adr   = busy && (ph < P_ADR);
  wire stb_win  = busy && !is_fetch && (ph >= P_SB) && (ph < P_SE);

  assign ready   = !busy || last;
  assign ale     = in_ale;
  assign psen_n  = !(busy && is_fetch && (ph >= P_ADR));
  assign rd_n    = !(stb_win && is_rd);
  assign wr_n    = !(stb_win && is_wr);
  assign ad_oe   = in_adr || (busy && is_wr);
  assign ad_out  = in_adr ? addr_q[7:0] : ((busy && is_wr) ? wd_q : 8'h00);
  assign hi_port = !busy ? 8'h00 :
                   (!is_fetch && in_ale) ? addr_q[23:16] : addr_q[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      kind_q <= 2'b00;
      addr_q <= '0;
      wd_q   <= '0;
      ph     <= '0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= last;
      if (capture) rdata <= ad_in;
      if (start) begin
        busy   <= 1'b1;
        ph     <= '0;
        kind_q <= kind;
        addr_q <= addr;
        wd_q   <= wdata;
      end else if (last) begin
        busy <= 1'b0;
        ph   <= '0;
      end else if (busy) begin
        ph <= ph + 1'b1;
      end
    end
  end

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic done
);

  a_r4_no_psen_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (rd_n && wr_n));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n));

  a_r5_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  a_r7_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  a_r7_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  a_r6_rd_not_single: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);

  a_r2_ale_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .done(done)
);

// File: tb/xbus_seq_test.sv
module xbus_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  ad_in = '0;
  logic        ready, done, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, ad_out, hi_port;

  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  xbus_seq uut (
    .clk(clk), .rst_n(rst_n), .req(req), .kind(kind), .addr(addr),
    .wdata(wdata), .ready(ready), .done(done), .rdata(rdata), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .hi_port(hi_port)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  function automatic int cyc_len(logic [1:0] k);
    return (k == 2'b00) ? 6 : 12;
  endfunction

  function automatic int cap_phase(logic [1:0] k);
    return (k == 2'b00) ? 5 : 10;
  endfunction

  // {ready, ale, psen_n, rd_n, wr_n, ad_oe, ad_out(masked), hi_port}
  function automatic logic [21:0] expv(logic [1:0] k, int p, logic [23:0] a, logic [7:0] wd);
    logic rdy, al, ps, rn, wn, oe;
    logic [7:0] ad, hi;
    rdy = (p == cyc_len(k) - 1);
    al  = (p < 2);
    ps  = 1'b1; rn = 1'b1; wn = 1'b1;
    oe  = (p < 3);
    ad  = (p < 3) ? a[7:0] : 8'h00;
    hi  = a[15:8];
    if (k == 2'b00) begin
      ps = !(p >= 3);
    end else begin
      hi = (p < 2) ? a[23:16] : a[15:8];
      if (k[1]) begin
        wn = !(p >= 5 && p <= 10);
        oe = 1'b1;
        if (p >= 3) ad = wd;
      end else begin
        rn = !(p >= 5 && p <= 10);
      end
    end
    return {rdy, al, ps, rn, wn, oe, ad, hi};
  endfunction

  function automatic logic [21:0] actv();
    return {ready, ale, psen_n, rd_n, wr_n, ad_oe, (ad_oe ? ad_out : 8'h00), hi_port};
  endfunction

  task automatic check_idle(string tag);
    chk({ready, ale, psen_n, rd_n, wr_n, ad_oe, done} == 7'b1011100, tag,
        {25'd0, ready, ale, psen_n, rd_n, wr_n, ad_oe, done}, 32'b1011100);
  endtask

  task automatic access(logic [1:0] k, logic [23:0] a, logic [7:0] wd, logic [7:0] rb);
    int n;
    string tag;
    n = cyc_len(k);
    tag = (k == 2'b00) ? "R2 R9 fetch" : "R4 R5 R6 R7 R9 data";
    @(negedge clk);
    req = 1'b1; kind = k; addr = a; wdata = wd; ad_in = ~rb;
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      if (p < n - 1) begin
        req = 1'b1; kind = 2'($urandom); addr = 24'($urandom); wdata = 8'($urandom);
      end else begin
        req = 1'b0;
      end
      ad_in = (p == cap_phase(k)) ? rb : ~rb;
      #1;
      chk(actv() == expv(k, p, a, wd), tag, {10'd0, actv()}, {10'd0, expv(k, p, a, wd)});
      chk(done == 1'b0, "R8 done early", {31'd0, done}, 32'd0);
    end
    @(negedge clk);
    ad_in = ~rb;
    chk(done == 1'b1, "R8 done pulse", {31'd0, done}, 32'd1);
    if (!k[1]) chk(rdata == rb, "R8 captured byte", {24'd0, rdata}, {24'd0, rb});
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    access(2'b00, 24'h00_FFFF, 8'h00, 8'h3C);
    access(2'b01, 24'hFF_FFFF, 8'h00, 8'hC3);
    access(2'b10, 24'h00_0000, 8'hA5, 8'h00);
    access(2'b11, 24'h12_3456, 8'h5A, 8'h00);
    access(2'b01, 24'hAB_0000, 8'h00, 8'h00);
    access(2'b00, 24'hFF_00FF, 8'h00, 8'hFF);

    for (int i = 0; i < 40; i++)
      access(2'($urandom), 24'($urandom), 8'($urandom), 8'($urandom));

    begin
      int last_fall, prev_ps;
      last_fall = -1;
      prev_ps = 1;
      @(negedge clk);
      req = 1'b1; kind = 2'b00; addr = 24'h00_1234;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (prev_ps == 1 && psen_n == 1'b0) begin
          if (last_fall >= 0)
            chk(c - last_fall == 6, "R3 fetch spacing", 32'(c - last_fall), 32'd6);
          last_fall = c;
        end
        prev_ps = int'(psen_n);
      end
      req = 1'b0;
      repeat (14) @(negedge clk);
    end

    @(negedge clk);
    req = 1'b1; kind = 2'b01; addr = 24'h55_AA55;
    @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R1 reset mid-cycle");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after mid-cycle reset");

    finish_run();
  end
endmodule